// File: doc/BRIEF.md
# Lazy Condition Code Evaluator

This block rebuilds the N, Z, V and C condition flags of a 32-bit integer core from a deferred record. Instead of computing flags after every instruction, the core saves an operation kind together with two values: the result and the second operand. When a later instruction needs the flags, this block turns that record into a 4-bit flag vector. The block is purely combinational. It supports these kinds:

- stored-flag pass-through
- logic
- add and subtract
- 8-bit and 16-bit compare
- add and subtract with extend
- shift

A second path, the extended arithmetic unit, performs add-with-extend and subtract-with-extend directly. It produces the 32-bit result, the new X bit and the flag vector. Its Z output can only be cleared, never set, so a multi-word chain keeps Z true only when every word is zero. The flag register that holds the previous Z and the X bit lives outside the block.

Top module: `ccx_lazy_flags`

## Requirements
- R1: The flag vector is ordered {N,Z,V,C} (bit 3 down to bit 0). Kind code 0 (pass-through) returns bits 3:0 of the saved result unchanged, with the error output low.
- R2: Kind code 1 (logic) sets Z when the result is zero and otherwise copies the result's bit 31 into N. V and C are 0.
- R3: Kind code 2 (add) treats the first operand as result minus second operand. C is the unsigned carry out of that addition and V is its signed overflow. N and Z come from the result.
- R4: Kind code 3 (subtract) treats the first operand as result plus second operand. C is the unsigned borrow of first minus second and V is the signed overflow of that subtraction. N and Z come from the result.
- R5: Kind codes 4 and 5 apply the subtract rule of R4 to the low 8 and the low 16 bits respectively. N is taken from bit 7 or bit 15, and Z from the narrowed result.
- R6: Kind code 6 (add with extend) and kind code 7 (subtract with extend) apply R3 and R4 with an extra carry-in or borrow-in of one. This gives C when the result is less than or equal to the second operand (code 6), or when the first operand is less than or equal to the second operand (code 7).
- R7: Kind code 8 (shift) takes N and Z from the result, sets C whenever the saved second value is nonzero, and clears V.
- R8: Kind codes 9 to 15 raise the error output and drive all four flags to 0. All other codes keep the error output low.
- R9: The extended arithmetic unit computes a+b+x or a-b-x with x the extend input. The X output is the carry (add) or borrow (subtract) of that operation and equals the C flag. V is its signed overflow and N the result's bit 31.
- R10: The extended arithmetic unit's Z output is the zero test of its result ANDed with the previous-Z input. A clear previous Z always yields a clear Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cc_kind | input | 4 | Recorded operation kind code |
| cc_res | input | 32 | Saved result value |
| cc_src | input | 32 | Saved second operand (or shift carry record) |
| cc_flags | output | 4 | Rebuilt flags {N,Z,V,C} |
| cc_err | output | 1 | Unknown kind code |
| ex_opa | input | 32 | Extended arithmetic first operand |
| ex_opb | input | 32 | Extended arithmetic second operand |
| ex_is_sub | input | 1 | 1 selects subtract, 0 selects add |
| ex_x_in | input | 1 | Current X bit (extra carry or borrow) |
| ex_z_prev | input | 1 | Previous Z flag |
| ex_res | output | 32 | Extended arithmetic result |
| ex_flags | output | 4 | Extended arithmetic flags {N,Z,V,C} |
| ex_x_out | output | 1 | New X bit |

## Verification
The bench sweeps every kind code over a grid of sign-boundary and all-ones operand pairs, plus a pseudo-random stream. It compares against first-operand reconstruction done in wide signed and unsigned arithmetic. The equal-operand cases target the extended kinds: a design that used strict less-than there would drop C exactly when the result equals the second operand. The 0x7F/0x80 and 0x7FFF/0x8000 pairs expose a compare that took N or overflow from bit 31 instead of the narrowed width. Running the extended unit with previous Z clear and a zero result catches a Z that is recomputed instead of made sticky, and codes 9 to 15 catch any stale flags left on an unknown kind.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
  localparam int unsigned KIND_W = 4;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FLG_N  = 3;
  localparam int unsigned FLG_Z  = 2;
  localparam int unsigned FLG_V  = 1;
  localparam int unsigned FLG_C  = 0;

  typedef enum logic [KIND_W-1:0] {
    KIND_PASS  = 4'd0,
    KIND_LOGIC = 4'd1,
    KIND_ADD   = 4'd2,
    KIND_SUB   = 4'd3,
    KIND_CMP8  = 4'd4,
    KIND_CMP16 = 4'd5,
    KIND_ADDX  = 4'd6,
    KIND_SUBX  = 4'd7,
    KIND_SHIFT = 4'd8
  } cc_kind_e;
endpackage

// File: rtl/ccx_nz.sv
module ccx_nz #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val,
  output logic         neg,
  output logic         zero
);
  always_comb begin
    zero = (val == '0);
    neg  = val[W-1];
  end
endmodule

// File: rtl/ccx_add_cv.sv
module ccx_add_cv #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res,
  input  logic [W-1:0] src,
  input  logic         ext,
  output logic         carry,
  output logic         ovf
);
  localparam int unsigned MSB = W - 1;
  logic [W-1:0] opa;

  always_comb begin
    opa   = res - src - W'(ext);
    carry = ext ? (res <= src) : (res < src);
    ovf   = (res[MSB] ^ src[MSB]) & ~(opa[MSB] ^ src[MSB]);
  end
endmodule

// File: rtl/ccx_sub_cv.sv
module ccx_sub_cv #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res,
  input  logic [W-1:0] src,
  input  logic         ext,
  output logic         carry,
  output logic         ovf
);
  localparam int unsigned MSB = W - 1;
  logic [W-1:0] opa;

  always_comb begin
    opa   = res + src + W'(ext);
    carry = ext ? (opa <= src) : (opa < src);
    ovf   = (opa[MSB] ^ res[MSB]) & (opa[MSB] ^ src[MSB]);
  end
endmodule

// File: rtl/ccx_flag_eval.sv
module ccx_flag_eval
  import ccx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HALF_W = 16
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [DATA_W-1:0] res,
  input  logic [DATA_W-1:0] src,
  output logic [FLAG_W-1:0] flags,
  output logic              err
);
  localparam int unsigned NARROW_N = 2;

  logic full_n, full_z;
  logic add_c, add_v, sub_c, sub_v;
  logic nar_n [NARROW_N];
  logic nar_z [NARROW_N];
  logic nar_c [NARROW_N];
  logic nar_v [NARROW_N];

  ccx_nz #(.W(DATA_W)) u_nz_full (.val(res), .neg(full_n), .zero(full_z));

  ccx_add_cv #(.W(DATA_W)) u_add (
    .res(res), .src(src), .ext(kind == KIND_ADDX), .carry(add_c), .ovf(add_v));

  ccx_sub_cv #(.W(DATA_W)) u_sub (
    .res(res), .src(src), .ext(kind == KIND_SUBX), .carry(sub_c), .ovf(sub_v));

  for (genvar g = 0; g < NARROW_N; g++) begin : g_narrow
    localparam int unsigned NW = (g == 0) ? BYTE_W : HALF_W;
    ccx_nz #(.W(NW)) u_nz (
      .val(res[NW-1:0]), .neg(nar_n[g]), .zero(nar_z[g]));
    ccx_sub_cv #(.W(NW)) u_cmp (
      .res(res[NW-1:0]), .src(src[NW-1:0]), .ext(1'b0),
      .carry(nar_c[g]), .ovf(nar_v[g]));
  end

  always_comb begin
    flags = '0;
    err   = 1'b0;
    case (kind)
      KIND_PASS:  flags = res[FLAG_W-1:0];
      KIND_LOGIC: flags = {full_n & ~full_z, full_z, 1'b0, 1'b0};
      KIND_ADD,
      KIND_ADDX:  flags = {full_n, full_z, add_v, add_c};
      KIND_SUB,
      KIND_SUBX:  flags = {full_n, full_z, sub_v, sub_c};
      KIND_CMP8:  flags = {nar_n[0], nar_z[0], nar_v[0], nar_c[0]};
      KIND_CMP16: flags = {nar_n[1], nar_z[1], nar_v[1], nar_c[1]};
      KIND_SHIFT: flags = {full_n, full_z, 1'b0, (src != '0)};
      default:    err   = 1'b1;
    endcase
  end

  always_comb begin
    if (err) begin
      AST_UNKNOWN_QUIET: assert (flags == '0) else $error("flags on unknown kind"); // R8
    end
    if (kind != KIND_PASS && !err) begin
      AST_NZ_EXCLUSIVE: assert (!(flags[FLG_N] && flags[FLG_Z])) else $error("N and Z both set"); // R2
    end
    if (kind == KIND_ADD && src == '0) begin
      AST_ADD_ZERO_SRC: assert (flags[FLG_C] == 1'b0 && flags[FLG_V] == 1'b0) else $error("add of zero"); // R3
    end
    if (kind == KIND_SUB && src == '0) begin
      AST_SUB_ZERO_SRC: assert (flags[FLG_C] == 1'b0 && flags[FLG_V] == 1'b0) else $error("sub of zero"); // R4
    end
    if (kind == KIND_SHIFT) begin
      AST_SHIFT_NO_V: assert (flags[FLG_V] == 1'b0) else $error("V on shift"); // R7
    end
  end
endmodule

// File: rtl/ccx_ext_arith.sv
module ccx_ext_arith
  import ccx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              is_sub,
  input  logic              x_in,
  input  logic              z_prev,
  output logic [DATA_W-1:0] res,
  output logic [FLAG_W-1:0] flags,
  output logic              x_out
);
  logic [KIND_W-1:0] kind;
  logic [FLAG_W-1:0] raw_flags;
  logic              raw_err;

  always_comb begin
    if (is_sub) begin
      res   = opa - opb - DATA_W'(x_in);
      kind  = x_in ? KIND_SUBX : KIND_SUB;
      x_out = x_in ? (opa <= opb) : (opa < opb);
    end else begin
      res   = opa + opb + DATA_W'(x_in);
      kind  = x_in ? KIND_ADDX : KIND_ADD;
      x_out = x_in ? (res <= opb) : (res < opb);
    end
  end

  ccx_flag_eval #(.DATA_W(DATA_W)) u_eval (
    .kind(kind), .res(res), .src(opb), .flags(raw_flags), .err(raw_err));

  always_comb begin
    flags        = raw_flags;
    flags[FLG_Z] = raw_flags[FLG_Z] & z_prev;
  end

  always_comb begin
    AST_X_MATCHES_C: assert (x_out == flags[FLG_C]) else $error("X differs from C"); // R9
    AST_EXT_KIND_OK: assert (!raw_err) else $error("wrapper kind invalid"); // R9
    if (!z_prev) begin
      AST_Z_STICKY: assert (!flags[FLG_Z]) else $error("Z set from clear"); // R10
    end
  end
endmodule

// File: rtl/ccx_lazy_flags.sv
module ccx_lazy_flags
  import ccx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [3:0]        cc_kind,
  input  logic [DATA_W-1:0] cc_res,
  input  logic [DATA_W-1:0] cc_src,
  output logic [3:0]        cc_flags,
  output logic              cc_err,
  input  logic [DATA_W-1:0] ex_opa,
  input  logic [DATA_W-1:0] ex_opb,
  input  logic              ex_is_sub,
  input  logic              ex_x_in,
  input  logic              ex_z_prev,
  output logic [DATA_W-1:0] ex_res,
  output logic [3:0]        ex_flags,
  output logic              ex_x_out
);
  ccx_flag_eval #(.DATA_W(DATA_W)) u_lazy (
    .kind(cc_kind), .res(cc_res), .src(cc_src),
    .flags(cc_flags), .err(cc_err));

  ccx_ext_arith #(.DATA_W(DATA_W)) u_ext (
    .opa(ex_opa), .opb(ex_opb), .is_sub(ex_is_sub), .x_in(ex_x_in),
    .z_prev(ex_z_prev), .res(ex_res), .flags(ex_flags), .x_out(ex_x_out));
endmodule

// File: tb/ccx_lazy_flags_tb.sv
module ccx_lazy_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic [3:0]  cc_kind;
  logic [31:0] cc_res, cc_src, ex_opa, ex_opb, ex_res;
  logic [3:0]  cc_flags, ex_flags;
  logic        cc_err, ex_is_sub, ex_x_in, ex_z_prev, ex_x_out;
  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5678;
  logic [31:0] grid [12];

  always #(CLK_PERIOD/2) clk = ~clk;

  ccx_lazy_flags u_dut (.*);

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  function automatic longint sx(input longint v, input int w);
    return (v >= (64'sd1 <<< (w-1))) ? v - (64'sd1 <<< w) : v;
  endfunction

  function automatic logic ovf(input longint v, input int w);
    return (v >= (64'sd1 <<< (w-1))) || (v < -(64'sd1 <<< (w-1)));
  endfunction

  // subtract-family model: first operand rebuilt, difference recomputed wide
  function automatic logic [3:0] m_sub(input logic [31:0] r, s, input int w, input int bin);
    longint mask = (64'sd1 <<< w) - 1;
    longint ur = longint'(r) & mask, us = longint'(s) & mask;
    longint ua = (ur + us + bin) & mask;
    logic c = (ua - us - bin) < 0;
    logic v = ovf(sx(ua, w) - sx(us, w) - bin, w);
    return {((ur >>> (w-1)) & 1) == 1, ur == 0, v, c};
  endfunction

  function automatic logic [3:0] m_add(input logic [31:0] r, s, input int cin);
    longint mask = (64'sd1 <<< 32) - 1;
    longint ur = longint'(r), us = longint'(s);
    longint ua = (ur - us - cin) & mask;
    logic c = (ua + us + cin) > mask;
    logic v = ovf(sx(ua, 32) + sx(us, 32) + cin, 32);
    return {r[31], r == 0, v, c};
  endfunction

  function automatic logic [4:0] model(input logic [3:0] k, input logic [31:0] r, s);
    case (k)
      4'd0: return {1'b0, r[3:0]};
      4'd1: return {1'b0, r[31], r == 0, 2'b00};
      4'd2: return {1'b0, m_add(r, s, 0)};
      4'd3: return {1'b0, m_sub(r, s, 32, 0)};
      4'd4: return {1'b0, m_sub(r, s, 8, 0)};
      4'd5: return {1'b0, m_sub(r, s, 16, 0)};
      4'd6: return {1'b0, m_add(r, s, 1)};
      4'd7: return {1'b0, m_sub(r, s, 32, 1)};
      4'd8: return {1'b0, r[31], r == 0, 1'b0, s != 0};
      default: return 5'b10000;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] k);
    case (k)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_cc(input logic [3:0] k, input logic [31:0] r, s);
    logic [4:0] e;
    @(negedge clk);
    cc_kind = k; cc_res = r; cc_src = s;
    #1;
    e = model(k, r, s);
    check(tag_of(k), {59'd0, cc_err, cc_flags}, {59'd0, e});
  endtask

  task automatic run_ex(input logic [31:0] a, b, input logic sub, x, zp);
    longint ua = longint'(a), ub = longint'(b), t;
    logic [31:0] er;
    logic ec, ev;
    if (sub) begin
      t = ua - ub - x; ec = t < 0;
      ev = ovf(sx(ua, 32) - sx(ub, 32) - x, 32);
    end else begin
      t = ua + ub + x; ec = t > 64'sd4294967295;
      ev = ovf(sx(ua, 32) + sx(ub, 32) + x, 32);
    end
    er = t[31:0];
    @(negedge clk);
    ex_opa = a; ex_opb = b; ex_is_sub = sub; ex_x_in = x; ex_z_prev = zp;
    #1;
    check("R9", {27'd0, ex_x_out, ex_flags[3], ex_flags[1:0], ex_res},
                {27'd0, ec, er[31], ev, ec, er});
    check("R10", {63'd0, ex_flags[2]}, {63'd0, (er == 0) && zp});
  endtask

  initial begin
    grid = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFF, 32'h7FFF, 32'h8000,
             32'hFFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'hA5C3_0F81};
    cc_kind = 4'd0; cc_res = '0; cc_src = '0;
    ex_opa = '0; ex_opb = '0; ex_is_sub = 1'b0; ex_x_in = 1'b0; ex_z_prev = 1'b1;
    #1;
    check("R1", {59'd0, cc_err, cc_flags}, 64'd0);
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          run_cc(4'(k), grid[i], grid[j]);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r1, r2;
      rng = next_rand(rng); r1 = rng;
      rng = next_rand(rng); r2 = (n % 4 == 0) ? r1 : rng;
      for (int k = 0; k < 16; k++) run_cc(4'(k), r1, r2);
    end
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int m = 0; m < 8; m++)
          run_ex(grid[i], grid[j], m[0], m[1], m[2]);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r1;
      rng = next_rand(rng); r1 = rng;
      rng = next_rand(rng);
      run_ex(r1, (n % 3 == 0) ? r1 : rng, rng[0], rng[1], rng[2]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule